// File: doc/BRIEF.md
# External Interrupt Source Selector

This block collects 32 external interrupt request lines into a sticky pending register. It masks them with a per-source enable mask and with the processor's global interrupt-enable bit, and drives one external interruption toward the core. Whatever the source, the interruption always carries interruption vector number 4. Software clears a pending bit by writing a 1 to its position.

Alongside the interruption, a read port tells the handler what to service. The block walks a programmable order table: each slot names a source index, and a count sets how many leading slots take part. The first slot whose source is both pending and enabled wins. If that source has a handler flagged, the port reports extended vector 32 + source. If the winning source has no handler, or no counted slot matches any active source, the port reports a spurious result instead.

Top module: `ext_irq_selector`

## Requirements
- R1: After synchronous reset, all pending bits, enables and handler flags are 0. Order slot i holds source i, and the slot count is 32. Every output is 0.
- R2: A request line that is 1 at a clock edge sets its pending bit at that edge. The bit stays 1 until it is cleared, whether or not the line stays high.
- R3: A 1 in clr_mask clears the matching pending bit at the edge. A request on the same bit in the same cycle wins, and the bit stays 1.
- R4: ext_irq_o is 1 exactly when gie is 1 and at least one pending bit has its enable set. It follows the pending register without added delay. int_vec_o reads 4 while ext_irq_o is 1 and 0 otherwise.
- R5: A pending source whose enable is 0 neither raises ext_irq_o nor can be selected. Its pending bit is still kept.
- R6: While gie is 0, ext_irq_o, sel_valid_o and sel_spur_o are 0 and sel_vec_o is 0, whatever is pending.
- R7: Among slots 0 up to count-1, the lowest-numbered slot whose source is pending and enabled is selected. With its handler flag set, sel_valid_o is 1 and sel_vec_o = 32 + source index.
- R8: Slots at or above the count are never examined. With count 0, every raised interruption is spurious.
- R9: When ext_irq_o is 1 and no valid vector results, sel_spur_o is 1, sel_valid_o is 0 and sel_vec_o is 0. This covers a selected source without a handler flag (later slots are not tried) and no counted slot matching. sel_valid_o and sel_spur_o are never 1 together.
- R10: Writes to enables, handler flags, order slots and count take effect from the next clock edge, not in the cycle of the write. A count above 32 is stored as 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 32 | Request lines, one per source |
| clr_mask | input | 32 | Write-1-to-clear mask for pending bits |
| en_we | input | 1 | Load the enable mask |
| en_data | input | 32 | New enable mask |
| hnd_we | input | 1 | Load the handler flags |
| hnd_data | input | 32 | New handler flags |
| ord_we | input | 1 | Write one order slot |
| ord_slot | input | 5 | Slot number to write |
| ord_src | input | 5 | Source index stored in the slot |
| cnt_we | input | 1 | Load the slot count |
| cnt_data | input | 6 | New slot count (saturated to 32) |
| gie | input | 1 | Global interrupt-enable bit |
| pend_o | output | 32 | Pending register contents |
| ext_irq_o | output | 1 | External interruption request to the core |
| int_vec_o | output | 6 | Interruption vector number (4 when raised) |
| sel_valid_o | output | 1 | A serviceable source was selected |
| sel_spur_o | output | 1 | Spurious result |
| sel_vec_o | output | 6 | Extended vector 32..63 of the selected source |

## Verification
The hardest case to reach is a contest between several active sources whose table order differs from their index order. It gets harder still when the count cuts the table so that an active source is never examined. To reach it, the bench reprograms the whole table into reverse order through the slot-write port. It then raises every pair of sources and checks each pair against an arithmetic model. Next it shrinks the count until pending sources fall outside the checked range. A source with no handler flag is placed ahead of one that has a flag, which shows that the block does not skip past it.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int unsigned NSRC_DEF     = 32;
    localparam int unsigned VEC_BASE_DEF = 32;
    localparam int unsigned EXT_VEC_DEF  = 4;

    typedef enum logic [1:0] {
        OUTC_NONE  = 2'd0,
        OUTC_VEC   = 2'd1,
        OUTC_SPUR  = 2'd2
    } outcome_e;

    function automatic int unsigned sat_count(input int unsigned raw, input int unsigned lim);
        return (raw > lim) ? lim : raw;
    endfunction

endpackage

// File: rtl/ext_irq_req_latch.sv
module ext_irq_req_latch #(
    parameter int unsigned NSRC = ext_irq_pkg::NSRC_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] req_in,
    input  logic [NSRC-1:0] clr_mask,
    output logic [NSRC-1:0] pend_q
);

    genvar b;
    generate
        for (b = 0; b < NSRC; b++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst)
                    pend_q[b] <= 1'b0;
                else if (req_in[b])
                    pend_q[b] <= 1'b1;
                else if (clr_mask[b])
                    pend_q[b] <= 1'b0;
            end
        end
    endgenerate

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
        (|req_in) |=> ((pend_q & $past(req_in)) == $past(req_in))); // R3

    AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(req_in)) == '0)); // R2

    AST_HOLD_WITHOUT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr_mask == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R2

endmodule

// File: rtl/ext_irq_cfg.sv
module ext_irq_cfg #(
    parameter int unsigned NSRC  = ext_irq_pkg::NSRC_DEF,
    parameter int unsigned IDX_W = $clog2(NSRC),
    parameter int unsigned CNT_W = $clog2(NSRC + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en_we,
    input  logic [NSRC-1:0]       en_data,
    input  logic                  hnd_we,
    input  logic [NSRC-1:0]       hnd_data,
    input  logic                  ord_we,
    input  logic [IDX_W-1:0]      ord_slot,
    input  logic [IDX_W-1:0]      ord_src,
    input  logic                  cnt_we,
    input  logic [CNT_W-1:0]      cnt_data,
    output logic [NSRC-1:0]       en_q,
    output logic [NSRC-1:0]       hnd_q,
    output logic [NSRC*IDX_W-1:0] ord_flat,
    output logic [CNT_W-1:0]      cnt_q
);
    import ext_irq_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NSRC);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            hnd_q <= '0;
            cnt_q <= CNT_MAX;
        end else begin
            if (en_we)  en_q  <= en_data;
            if (hnd_we) hnd_q <= hnd_data;
            if (cnt_we) cnt_q <= CNT_W'(sat_count(int'(cnt_data), NSRC));
        end
    end

    genvar s;
    generate
        for (s = 0; s < NSRC; s++) begin : g_slot
            logic [IDX_W-1:0] slot_q;
            always_ff @(posedge clk) begin
                if (rst)
                    slot_q <= IDX_W'(s);
                else if (ord_we && (ord_slot == IDX_W'(s)))
                    slot_q <= ord_src;
            end
            assign ord_flat[s*IDX_W +: IDX_W] = slot_q;
        end
    endgenerate

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_we |=> (cnt_q <= CNT_MAX)); // R10

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!en_we && !hnd_we) |=> ($stable(en_q) && $stable(hnd_q))); // R10

endmodule

// File: rtl/ext_irq_scan.sv
module ext_irq_scan #(
    parameter int unsigned NSRC  = ext_irq_pkg::NSRC_DEF,
    parameter int unsigned IDX_W = $clog2(NSRC),
    parameter int unsigned CNT_W = $clog2(NSRC + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NSRC-1:0]       active,
    input  logic [NSRC*IDX_W-1:0] ord_flat,
    input  logic [CNT_W-1:0]      cnt,
    output logic                  hit,
    output logic [IDX_W-1:0]      hit_src,
    output logic [IDX_W-1:0]      hit_slot
);

    logic [NSRC-1:0] slot_live;

    genvar s;
    generate
        for (s = 0; s < NSRC; s++) begin : g_probe
            logic [IDX_W-1:0] src_s;
            assign src_s        = ord_flat[s*IDX_W +: IDX_W];
            assign slot_live[s] = (CNT_W'(s) < cnt) && active[src_s];
        end
    endgenerate

    always_comb begin
        hit      = 1'b0;
        hit_slot = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (slot_live[i]) begin
                hit      = 1'b1;
                hit_slot = IDX_W'(i);
            end
        end
        hit_src = ord_flat[hit_slot*IDX_W +: IDX_W];
    end

    AST_HIT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        hit |-> ((CNT_W'(hit_slot) < cnt) && active[hit_src])); // R8

    AST_MISS_MEANS_NONE: assert property (@(posedge clk) disable iff (rst)
        (!hit) |-> (slot_live == '0)); // R8

endmodule

// File: rtl/ext_irq_selector.sv
module ext_irq_selector #(
    parameter int unsigned NSRC     = ext_irq_pkg::NSRC_DEF,
    parameter int unsigned VEC_BASE = ext_irq_pkg::VEC_BASE_DEF,
    parameter int unsigned EXT_VEC  = ext_irq_pkg::EXT_VEC_DEF,
    parameter int unsigned IDX_W    = $clog2(NSRC),
    parameter int unsigned CNT_W    = $clog2(NSRC + 1),
    parameter int unsigned VEC_W    = $clog2(VEC_BASE + NSRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  req_in,
    input  logic [NSRC-1:0]  clr_mask,
    input  logic             en_we,
    input  logic [NSRC-1:0]  en_data,
    input  logic             hnd_we,
    input  logic [NSRC-1:0]  hnd_data,
    input  logic             ord_we,
    input  logic [IDX_W-1:0] ord_slot,
    input  logic [IDX_W-1:0] ord_src,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_data,
    input  logic             gie,
    output logic [NSRC-1:0]  pend_o,
    output logic             ext_irq_o,
    output logic [VEC_W-1:0] int_vec_o,
    output logic             sel_valid_o,
    output logic             sel_spur_o,
    output logic [VEC_W-1:0] sel_vec_o
);
    import ext_irq_pkg::*;

    logic [NSRC-1:0]       pend_q;
    logic [NSRC-1:0]       en_q;
    logic [NSRC-1:0]       hnd_q;
    logic [NSRC*IDX_W-1:0] ord_flat;
    logic [CNT_W-1:0]      cnt_q;
    logic [NSRC-1:0]       active;
    logic                  hit;
    logic [IDX_W-1:0]      hit_src;
    logic [IDX_W-1:0]      hit_slot;
    logic                  raise;
    outcome_e              outc;

    ext_irq_req_latch #(.NSRC(NSRC)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .req_in   (req_in),
        .clr_mask (clr_mask),
        .pend_q   (pend_q)
    );

    ext_irq_cfg #(.NSRC(NSRC), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .en_we    (en_we),
        .en_data  (en_data),
        .hnd_we   (hnd_we),
        .hnd_data (hnd_data),
        .ord_we   (ord_we),
        .ord_slot (ord_slot),
        .ord_src  (ord_src),
        .cnt_we   (cnt_we),
        .cnt_data (cnt_data),
        .en_q     (en_q),
        .hnd_q    (hnd_q),
        .ord_flat (ord_flat),
        .cnt_q    (cnt_q)
    );

    assign active = pend_q & en_q;

    ext_irq_scan #(.NSRC(NSRC), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_scan (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .ord_flat (ord_flat),
        .cnt      (cnt_q),
        .hit      (hit),
        .hit_src  (hit_src),
        .hit_slot (hit_slot)
    );

    assign raise = gie && (|active);

    always_comb begin
        if (!raise)
            outc = OUTC_NONE;
        else if (hit && hnd_q[hit_src])
            outc = OUTC_VEC;
        else
            outc = OUTC_SPUR;
    end

    assign pend_o      = pend_q;
    assign ext_irq_o   = raise;
    assign int_vec_o   = raise ? VEC_W'(EXT_VEC) : '0;
    assign sel_valid_o = (outc == OUTC_VEC);
    assign sel_spur_o  = (outc == OUTC_SPUR);
    assign sel_vec_o   = (outc == OUTC_VEC) ? VEC_W'(VEC_BASE) + VEC_W'(hit_src) : '0;

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        ext_irq_o |-> (sel_valid_o ^ sel_spur_o)); // R9

    AST_QUIET_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        (!ext_irq_o) |-> (!sel_valid_o && !sel_spur_o && sel_vec_o == '0)); // R6

    AST_VEC_IS_LIVE: assert property (@(posedge clk) disable iff (rst)
        sel_valid_o |-> (pend_q[hit_src] && en_q[hit_src] && hnd_q[hit_src])); // R7

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        ext_irq_o |-> ((pend_o & en_q) != '0)); // R4

endmodule

// File: tb/tb_ext_irq_selector.sv
module tb_ext_irq_selector;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] req_in, clr_mask, en_data, hnd_data;
    logic        en_we, hnd_we, ord_we, cnt_we, gie;
    logic [4:0]  ord_slot, ord_src;
    logic [5:0]  cnt_data;
    logic [31:0] pend_o;
    logic        ext_irq_o, sel_valid_o, sel_spur_o;
    logic [5:0]  int_vec_o, sel_vec_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] sh_pend, sh_en, sh_hnd;
    logic [4:0]  sh_ord [32];
    int          sh_cnt;

    always #4 clk = ~clk;

    ext_irq_selector dut (
        .clk(clk), .rst(rst), .req_in(req_in), .clr_mask(clr_mask),
        .en_we(en_we), .en_data(en_data), .hnd_we(hnd_we), .hnd_data(hnd_data),
        .ord_we(ord_we), .ord_slot(ord_slot), .ord_src(ord_src),
        .cnt_we(cnt_we), .cnt_data(cnt_data), .gie(gie),
        .pend_o(pend_o), .ext_irq_o(ext_irq_o), .int_vec_o(int_vec_o),
        .sel_valid_o(sel_valid_o), .sel_spur_o(sel_spur_o), .sel_vec_o(sel_vec_o)
    );

    task automatic check_out(input string tag);
        logic [31:0] act;
        logic        e_irq, e_hit, e_val, e_spur;
        logic [4:0]  e_src;
        logic [5:0]  e_vec, e_iv;
        act   = sh_pend & sh_en;
        e_irq = gie && (act != 0);
        e_hit = 1'b0;
        e_src = '0;
        for (int i = 0; i < sh_cnt; i++) begin
            if (!e_hit && act[sh_ord[i]]) begin
                e_hit = 1'b1;
                e_src = sh_ord[i];
            end
        end
        e_val  = e_irq && e_hit && sh_hnd[e_src];
        e_spur = e_irq && !e_val;
        e_vec  = e_val ? 6'(32 + int'(e_src)) : 6'd0;
        e_iv   = e_irq ? 6'd4 : 6'd0;
        n_cmp++;
        if (pend_o !== sh_pend || ext_irq_o !== e_irq || int_vec_o !== e_iv ||
            sel_valid_o !== e_val || sel_spur_o !== e_spur || sel_vec_o !== e_vec) begin
            n_bad++;
            $display("FAIL %s: got pend=%h irq=%b iv=%0d val=%b spur=%b vec=%0d exp pend=%h irq=%b iv=%0d val=%b spur=%b vec=%0d",
                     tag, pend_o, ext_irq_o, int_vec_o, sel_valid_o, sel_spur_o, sel_vec_o,
                     sh_pend, e_irq, e_iv, e_val, e_spur, e_vec);
        end
    endtask

    task automatic tick_req(input logic [31:0] r, input logic [31:0] c);
        req_in   = r;
        clr_mask = c;
        @(posedge clk);
        sh_pend = (sh_pend & ~c) | r;
        @(negedge clk);
        req_in   = '0;
        clr_mask = '0;
    endtask

    task automatic set_en(input logic [31:0] m);
        en_we = 1'b1; en_data = m;
        @(posedge clk); sh_en = m;
        @(negedge clk); en_we = 1'b0;
    endtask

    task automatic set_hnd(input logic [31:0] m);
        hnd_we = 1'b1; hnd_data = m;
        @(posedge clk); sh_hnd = m;
        @(negedge clk); hnd_we = 1'b0;
    endtask

    task automatic set_cnt(input logic [5:0] c);
        cnt_we = 1'b1; cnt_data = c;
        @(posedge clk); sh_cnt = (c > 6'd32) ? 32 : int'(c);
        @(negedge clk); cnt_we = 1'b0;
    endtask

    task automatic set_slot(input int s, input int src);
        ord_we = 1'b1; ord_slot = 5'(s); ord_src = 5'(src);
        @(posedge clk); sh_ord[s] = 5'(src);
        @(negedge clk); ord_we = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got no completion exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_in = '0; clr_mask = '0; en_we = 0; en_data = '0;
        hnd_we = 0; hnd_data = '0; ord_we = 0; ord_slot = '0; ord_src = '0;
        cnt_we = 0; cnt_data = '0; gie = 1'b1;
        sh_pend = '0; sh_en = '0; sh_hnd = '0; sh_cnt = 32;
        for (int i = 0; i < 32; i++) sh_ord[i] = 5'(i);
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        check_out("R1 reset state");
        // R1: requests with nothing enabled stay silent but pend
        tick_req(32'h8000_0001, '0);
        check_out("R1 R5 reset enables are zero");
        tick_req('0, 32'hFFFF_FFFF);
        check_out("R3 clear all");

        // R10: write not visible in its own cycle
        tick_req(32'h0000_0100, '0);
        en_we = 1'b1; en_data = 32'hFFFF_FFFF;
        #1 check_out("R10 enable write not yet visible");
        @(posedge clk); sh_en = 32'hFFFF_FFFF;
        @(negedge clk); en_we = 1'b0;
        check_out("R10 enable write visible next cycle");
        tick_req('0, 32'h0000_0100);
        set_hnd(32'hFFFF_FFFF);

        // R2 R4 R7: single-source sweep, identity order
        for (int n = 0; n < 32; n++) begin
            tick_req(32'(1) << n, '0);
            check_out("R2 R4 R7 single source");
            tick_req('0, '0);
            check_out("R2 sticky after line drops");
            tick_req('0, 32'(1) << n);
            check_out("R3 write-one clear");
        end

        // R7: reversed table, every pair
        for (int i = 0; i < 32; i++) set_slot(i, 31 - i);
        for (int a = 0; a < 32; a++) begin
            for (int b = a + 1; b < 32; b++) begin
                tick_req((32'(1) << a) | (32'(1) << b), '0);
                check_out("R7 pair in reversed order");
                tick_req('0, 32'hFFFF_FFFF);
            end
        end

        // R3: set wins over clear
        tick_req(32'h0000_0020, '0);
        tick_req(32'h0000_0020, 32'h0000_0020);
        check_out("R3 set beats clear");
        tick_req('0, 32'h0000_0020);
        check_out("R3 clear after contest");

        // R5: disabled source kept but ignored
        set_en(32'hFFFF_FF7F);
        tick_req(32'h0000_0080, '0);
        check_out("R5 disabled source");
        tick_req(32'h0000_0200, '0);
        check_out("R5 enabled source beside disabled");
        tick_req('0, 32'hFFFF_FFFF);
        set_en(32'hFFFF_FFFF);

        // R6: global disable
        tick_req(32'h0F0F_0F0F, '0);
        gie = 1'b0;
        #1 check_out("R6 gie low");
        gie = 1'b1;
        #1 check_out("R6 gie restored");

        // R8: count cuts the table (reversed: slots 0..3 = sources 31..28)
        tick_req('0, 32'hFFFF_FFFF);
        set_cnt(6'd4);
        tick_req(32'h0000_0008, '0);
        check_out("R8 R9 source outside count");
        tick_req(32'h2000_0000, '0);
        check_out("R8 source inside count");
        set_cnt(6'd0);
        check_out("R8 count zero spurious");
        set_cnt(6'd40);
        check_out("R10 count saturates to 32");
        tick_req('0, 32'hFFFF_FFFF);

        // R9: selected source lacks handler, later slot not tried
        for (int i = 0; i < 32; i++) set_slot(i, i);
        set_hnd(32'hFFFF_FBFF);
        tick_req(32'h0000_1400, '0);
        check_out("R9 missing handler no skip");
        tick_req('0, 32'h0000_0400);
        check_out("R9 handler present after clear");
        tick_req('0, 32'hFFFF_FFFF);
        check_out("R4 all clear no irq");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule